// File: doc/BRIEF.md
# Circular Spy Capture Buffer

This block keeps a running record of a data stream for diagnosis. Each word that goes by with its valid strobe is copied into a circular RAM. The copy is taken without back-pressure, so the stream never waits on the block. A write pointer names the slot that takes the next word. When the pointer passes the last slot it returns to zero and starts overwriting the oldest entries. A sticky wrap flag records that this has happened at least once. Once the flag is set, every slot holds a captured word, including the slots from the pointer up to the end of the buffer.

An active-low freeze input stops capture so that the buffer can be examined like the snapshot of a logic analyser. While frozen, the memory and the pointer hold their values. Software uses a small register bus with read and write strobes to fetch stored words, the pointer, the wrap flag and the live freeze state. A buffer read is only served while frozen; otherwise the block signals a bus error. Releasing the freeze resumes capture at the slot where it stopped. The pointer and the wrap flag can each be cleared by a write.

Top module: `spy_capture_buffer`

## Requirements
- R1: A stored word is 23 bits: stream data in bits [20:0], the end-of-packet marker in bit 21 and the end-of-event marker in bit 22. A buffer read returns this word in bus_rdata[22:0] with bits [31:23] zero.
- R2: On every rising edge where cap_valid is high and the block is not frozen, the word is written at the slot the pointer names, and the pointer then advances by one.
- R3: When a word is captured at slot DEPTH-1, the pointer returns to 0. Later words overwrite slots 0, 1, ... in order, and the slots not yet overwritten keep their older contents.
- R4: After reset the pointer is 0, the wrap flag is 0 and the block reports not frozen.
- R5: The wrap flag sets on the first capture into slot DEPTH-1 and then stays set until it is cleared by a write.
- R6: freeze_n passes through a two-flop synchroniser. While its synchronised level is low, no capture takes place, and both the buffer contents and the pointer stay unchanged. The freeze covers capture strobes from the third rising edge after freeze_n falls.
- R7: After freeze_n returns high, capture resumes at the pointer value held during the freeze.
- R8: The status register is at bus address 0 and can be read at any time. It holds the pointer in bits [PTR_W-1:0], the wrap flag in bit 30 and the synchronised freeze state in bit 31 (1 means frozen). All other bits are 0.
- R9: bus_err pulses for one cycle, with bus_rvalid low, in three cases: a buffer read while not frozen, any write to the buffer window, and any read or write to an address that has the top bit 0 and is not 0. The buffer window is the set of addresses with the top bit (bit PTR_W) set; the low PTR_W bits select the slot.
- R10: A write to address 0 clears the pointer when data bit 0 is 1 and clears the wrap flag when data bit 1 is 1. A pointer clear wins over a capture in the same cycle.
- R11: A valid read returns its data with bus_rvalid high on the rising edge after the edge that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Stream word valid strobe |
| cap_data | input | 21 | Stream data |
| cap_end_pkt | input | 1 | End-of-packet marker of the stream word |
| cap_end_evt | input | 1 | End-of-event marker of the stream word |
| freeze_n | input | 1 | Asynchronous active-low freeze request |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | PTR_W+1 (11) | Word address; top bit selects the buffer window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Bus error pulse |

## Verification
On every cycle, the assertions check the pointer's behaviour against the capture strobe, the synchronised freeze and the clears. They check that the pointer holds while frozen, advances by one on a capture, returns to zero at the last slot and drops to zero on a clear. They also check that the wrap flag sets at the last slot and then stays set, and that a buffer read made while not frozen ends in an error and not in data. Only the bench's scenarios can show that stored words come back intact and with the right field layout. The same goes for the following: the contents outside the pointer's path survive a freeze and a wrap, and capture resumes at the held slot after release. The status word packing and the error cases for writes and unmapped addresses are also shown by the scenarios.

// File: rtl/spy_pkg.sv
package spy_pkg;
  localparam int DATA_W = 21;
  localparam int WORD_W = DATA_W + 2;
  localparam int BUS_W = 32;
  localparam int STAT_WRAP_BIT = 30;
  localparam int STAT_FRZ_BIT = 31;
  localparam int CLR_PTR_BIT = 0;
  localparam int CLR_WRAP_BIT = 1;

  typedef struct packed {
    logic              end_evt;
    logic              end_pkt;
    logic [DATA_W-1:0] data;
  } spy_word_t;
endpackage

// File: rtl/spy_freeze_sync.sv
module spy_freeze_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze_n,
  output logic frozen
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], freeze_n};
  end

  assign frozen = ~sh[STAGES-1];
endmodule

// File: rtl/spy_ptr_ctrl.sv
module spy_ptr_ctrl #(
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             clr_ptr,
  input  logic             clr_wrap,
  output logic [PTR_W-1:0] ptr,
  output logic             wrap
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      wrap <= 1'b0;
    end else begin
      if (clr_ptr)
        ptr <= '0;
      else if (cap_en)
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;

      if (clr_wrap)
        wrap <= 1'b0;
      else if (cap_en && ptr == LAST)
        wrap <= 1'b1;
    end
  end
endmodule

// File: rtl/spy_ram.sv
module spy_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 23,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spy_bus_regs.sv
module spy_bus_regs
  import spy_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              wrap,
  input  logic              frozen,
  input  logic [WORD_W-1:0] ram_q,
  output logic              clr_ptr,
  output logic              clr_wrap,
  output logic              ram_re,
  output logic [PTR_W-1:0]  ram_raddr,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err
);
  logic is_buf, is_stat;
  logic rd_buf_ok, rd_stat, bad_access, wr_stat;
  logic [BUS_W-1:0] stat_word, stat_q;
  logic sel_buf_q;

  assign is_buf    = bus_addr[ADDR_W-1];
  assign is_stat   = (bus_addr == '0);
  assign rd_buf_ok = bus_rd && is_buf && frozen;
  assign rd_stat   = bus_rd && is_stat;
  assign wr_stat   = bus_wr && is_stat;
  assign bad_access = (bus_rd && !rd_buf_ok && !rd_stat) || (bus_wr && !is_stat);

  assign clr_ptr   = wr_stat && bus_wdata[CLR_PTR_BIT];
  assign clr_wrap  = wr_stat && bus_wdata[CLR_WRAP_BIT];
  assign ram_re    = rd_buf_ok;
  assign ram_raddr = bus_addr[PTR_W-1:0];

  always_comb begin
    stat_word = '0;
    stat_word[PTR_W-1:0]     = ptr;
    stat_word[STAT_WRAP_BIT] = wrap;
    stat_word[STAT_FRZ_BIT]  = frozen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      sel_buf_q  <= 1'b0;
      stat_q     <= '0;
    end else begin
      bus_rvalid <= rd_buf_ok || rd_stat;
      bus_err    <= bad_access;
      sel_buf_q  <= rd_buf_ok;
      if (rd_stat) stat_q <= stat_word;
    end
  end

  assign bus_rdata = sel_buf_q ? {{(BUS_W-WORD_W){1'b0}}, ram_q} : stat_q;
endmodule

// File: rtl/spy_capture_buffer.sv
module spy_capture_buffer
  import spy_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_end_pkt,
  input  logic              cap_end_evt,
  input  logic              freeze_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err
);
  logic frozen, cap_en, clr_ptr, clr_wrap, wrap, ram_re;
  logic [PTR_W-1:0] ptr, ram_raddr;
  logic [WORD_W-1:0] ram_q;
  spy_word_t word_in;

  assign word_in = '{end_evt: cap_end_evt, end_pkt: cap_end_pkt, data: cap_data};
  assign cap_en  = cap_valid && !frozen;

  spy_freeze_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .freeze_n(freeze_n), .frozen(frozen)
  );

  spy_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .cap_en(cap_en), .clr_ptr(clr_ptr),
    .clr_wrap(clr_wrap), .ptr(ptr), .wrap(wrap)
  );

  spy_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
    .clk(clk), .we(cap_en), .waddr(ptr), .wdata(word_in),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  spy_bus_regs #(.DEPTH(DEPTH)) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ptr(ptr), .wrap(wrap),
    .frozen(frozen), .ram_q(ram_q), .clr_ptr(clr_ptr), .clr_wrap(clr_wrap),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err)
  );
endmodule

// File: rtl/spy_capture_buffer_chk.sv
module spy_capture_buffer_chk #(
  parameter int DEPTH = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              frozen,
  input logic              cap_valid,
  input logic              clr_ptr,
  input logic              clr_wrap,
  input logic [PTR_W-1:0]  ptr,
  input logic              wrap,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              bus_err
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  AST_PTR_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (frozen && !clr_ptr) |=> ptr == $past(ptr)); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !frozen && !clr_ptr && ptr != LAST) |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R2

  AST_PTR_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !frozen && ptr == LAST) |=> ptr == '0); // R3

  AST_WRAP_SET: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !frozen && ptr == LAST && !clr_wrap) |=> wrap); // R5

  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wrap && !clr_wrap) |=> wrap); // R5

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_ptr |=> ptr == '0); // R10

  AST_LIVE_BUF_READ_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[ADDR_W-1] && !frozen) |=> (bus_err && !bus_rvalid)); // R9
endmodule

bind spy_capture_buffer spy_capture_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .frozen(frozen), .cap_valid(cap_valid),
  .clr_ptr(clr_ptr), .clr_wrap(clr_wrap), .ptr(ptr), .wrap(wrap),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rvalid(bus_rvalid),
  .bus_err(bus_err)
);

// File: tb/test_spy_capture_buffer.sv
`timescale 1ns/1ps
module test_spy_capture_buffer;
  localparam int DEPTH = 1024;
  localparam int PW = 10;
  localparam int AW = PW + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cap_valid = 1'b0, cap_end_pkt = 1'b0, cap_end_evt = 1'b0, freeze_n = 1'b1;
  logic [20:0] cap_data = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, bus_err;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [22:0] mdl_mem [DEPTH];
  int mdl_ptr = 0;
  bit mdl_wrap = 0, mdl_frz = 0;

  always #2.5 clk = ~clk;

  spy_capture_buffer i_spy_capture_buffer (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_end_pkt(cap_end_pkt), .cap_end_evt(cap_end_evt), .freeze_n(freeze_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] pat(input int i);
    return {i[0], i[1], 21'(32'h0A5A5 ^ (i * 37))};
  endfunction

  function automatic logic [31:0] stat_exp();
    logic [31:0] s = '0;
    s[PW-1:0] = PW'(mdl_ptr);
    s[30] = mdl_wrap;
    s[31] = mdl_frz;
    return s;
  endfunction

  task automatic push(input logic [22:0] w);
    @(negedge clk);
    cap_valid = 1'b1; {cap_end_evt, cap_end_pkt, cap_data} = w;
    @(negedge clk);
    cap_valid = 1'b0;
    if (!mdl_frz) begin
      mdl_mem[mdl_ptr] = w;
      if (mdl_ptr == DEPTH - 1) begin mdl_ptr = 0; mdl_wrap = 1; end
      else mdl_ptr++;
    end
  endtask

  task automatic set_freeze(input bit f);
    @(negedge clk);
    freeze_n = ~f;
    repeat (3) @(negedge clk);
    mdl_frz = f;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d,
                          output logic v, output logic e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid; e = bus_err;
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    e = bus_err;
    bus_wr = 1'b0;
  endtask

  task automatic check_status(input string req);
    logic [31:0] d; logic v, e;
    bus_read('0, d, v, e);
    chk(req, {30'b0, v, e}, 32'h2);
    chk(req, d, stat_exp());
  endtask

  task automatic check_slot(input string req, input int slot);
    logic [31:0] d; logic v, e;
    bus_read({1'b1, PW'(slot)}, d, v, e);
    chk(req, {30'b0, v, e}, 32'h2);
    chk(req, d, {9'b0, mdl_mem[slot]});
  endtask

  task automatic t_reset();
    check_status("R4 reset status");
  endtask

  task automatic t_capture_freeze();
    logic [31:0] d; logic v, e;
    for (int i = 0; i < 5; i++) push(pat(i));
    check_status("R2 pointer after five captures");
    bus_read({1'b1, PW'(0)}, d, v, e);
    chk("R9 live buffer read errors", {30'b0, v, e}, 32'h1);
    set_freeze(1);
    check_status("R8 frozen bit in status");
    for (int i = 0; i < 5; i++) check_slot("R1 stored word layout", i);
    push(pat(99)); push(pat(98));
    check_status("R6 pointer held while frozen");
    for (int i = 0; i < 5; i++) check_slot("R6 contents held while frozen", i);
    set_freeze(0);
    push(pat(5));
    set_freeze(1);
    check_status("R7 resume at held pointer");
    check_slot("R7 word written at held slot", 5);
    chk("R7 pointer is six", 32'(mdl_ptr), 32'd6);
  endtask

  task automatic t_wrap();
    set_freeze(0);
    for (int i = 6; i < DEPTH - 1; i++) push(pat(i));
    check_status("R5 no wrap before last slot");
    push(pat(DEPTH - 1));
    check_status("R5 wrap flag set, R3 pointer at zero");
    push(pat(2000)); push(pat(2001));
    check_status("R5 wrap flag sticky");
    set_freeze(1);
    check_slot("R3 slot 0 overwritten", 0);
    check_slot("R3 slot 1 overwritten", 1);
    check_slot("R3 slot 2 keeps old word", 2);
    check_slot("R3 last slot kept", DEPTH - 1);
    chk("R3 slot 0 holds new word", {9'b0, mdl_mem[0]}, {9'b0, pat(2000)});
  endtask

  task automatic t_clear();
    logic e;
    bus_write('0, 32'h1, e);
    chk("R10 clear write no error", {31'b0, e}, 32'h0);
    mdl_ptr = 0;
    check_status("R10 pointer cleared, wrap kept");
    bus_write('0, 32'h2, e);
    mdl_wrap = 0;
    check_status("R10 wrap flag cleared");
    set_freeze(0);
    push(pat(7)); push(pat(8));
    @(negedge clk);
    cap_valid = 1'b1; {cap_end_evt, cap_end_pkt, cap_data} = pat(9);
    bus_wr = 1'b1; bus_addr = '0; bus_wdata = 32'h1;
    @(negedge clk);
    cap_valid = 1'b0; bus_wr = 1'b0;
    mdl_ptr = 0;
    check_status("R10 clear wins over capture");
  endtask

  task automatic t_errors();
    logic [31:0] d; logic v, e;
    bus_write({1'b1, PW'(3)}, 32'h5, e);
    chk("R9 buffer write errors", {31'b0, e}, 32'h1);
    bus_read(AW'(1), d, v, e);
    chk("R9 unmapped read errors", {30'b0, v, e}, 32'h1);
    bus_write(AW'(4), 32'h3, e);
    chk("R9 unmapped write errors", {31'b0, e}, 32'h1);
    check_status("R9 status untouched by bad writes");
    @(negedge clk); bus_rd = 1'b1; bus_addr = '0;
    @(posedge clk); #1;
    chk("R11 data valid one edge after request", {31'b0, bus_rvalid}, 32'h1);
    @(negedge clk); bus_rd = 1'b0;
    @(negedge clk);
    chk("R9 error pulse ends", {31'b0, bus_err}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_capture_freeze();
    t_wrap();
    t_clear();
    t_errors();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule